// File: doc/BRIEF.md
# CAN Identifier Acceptance Filter

This block sits behind a CAN receive engine and decides, once per received frame, whether the frame is kept. The engine presents the identifier, the extended-format flag and the remote-request flag with a one-cycle strobe. The block rebuilds the 32-bit header word that the frame carried on the bus. It then compares that word against a bank of programmable code/mask pairs.

Eight code bytes and eight mask bytes form the bank. One mode register chooses how the bank is split: two wide filters over the whole header word, four medium filters over its first 16 bits, or eight narrow filters over its first byte. A fourth setting closes the filter entirely. One clock after the strobe, the block reports whether any filter matched and which one. Software programs the bank through a byte-wide register port, and only while the init-mode input is high.

Top module: `can_id_filter`

## Requirements
- R1: After a synchronous reset, `accept` is 0 and `hit_idx` is 0, and the mode register holds the closed setting (3).
- R2: A mask bit of 1 excludes that header bit from the comparison. A mask bit of 0 requires the header bit to equal the code bit.
- R3: The header word is built MSB first. For extended frames it is {id[28:18], 1, 1, id[17:0], rtr}. For standard frames it is {id[10:0], rtr, 0, 19 zeros}.
- R4: Mode 0 gives two 32-bit filters. Filter 0 uses bytes 0..3 and filter 1 uses bytes 4..7. Byte 0 lines up with header bits 31:24.
- R5: Mode 1 gives four 16-bit filters. Filter i uses bytes 2i and 2i+1 against header bits 31:16.
- R6: Mode 2 gives eight 8-bit filters. Filter i uses byte i against header bits 31:24.
- R7: When several filters match, `hit_idx` reports the lowest-numbered one.
- R8: The result updates on the clock edge that samples `rx_valid` high and holds until the next strobe. A rejected frame gives `hit_idx` = 0.
- R9: Mode 3 (closed) rejects every frame.
- R10: Register writes made while `init_mode` is low change neither the bank nor the mode.
- R11: Register addresses: 0..7 are code bytes 0..7, 8..15 are mask bytes 0..7, and 16 is the mode, taken from wdata[1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| init_mode | input | 1 | Configuration writes permitted while high |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register address |
| cfg_wdata | input | 8 | Register write data |
| rx_valid | input | 1 | One-cycle strobe for a received identifier |
| rx_id | input | 29 | Received identifier (standard frames use bits 10:0) |
| rx_ide | input | 1 | 1 = extended frame |
| rx_rtr | input | 1 | 1 = remote frame |
| accept | output | 1 | Frame accepted by some filter |
| hit_idx | output | 3 | Lowest matching filter number |

## Verification
Every split mode is tried with header words that hit exactly one filter, words that hit several filters, and words that hit none. These separate a correct priority order from a correct match vector. Pairs of words that differ only in the RTR bit, or only in a masked field, show that the comparison really includes or excludes those bits. Standard frames are placed next to extended frames that share the same leading bits, so that the IDE and SRR positions in the header word are checked. Directed tests cover the closed mode, writes made outside init mode, and the result holding between strobes.

// File: rtl/can_id_filter_pkg.sv
package can_id_filter_pkg;

    localparam int HDR_W = 32;

    typedef enum logic [1:0] {
        AF_W32    = 2'd0,
        AF_W16    = 2'd1,
        AF_W8     = 2'd2,
        AF_CLOSED = 2'd3
    } af_mode_e;

    typedef struct packed {
        logic [28:0] id;
        logic        ide;
        logic        rtr;
    } rx_hdr_t;

    // Rebuild the header word in on-bus bit order (first bit at MSB).
    function automatic logic [HDR_W-1:0] build_hdr(rx_hdr_t h);
        logic [HDR_W-1:0] w;
        if (h.ide)
            w = {h.id[28:18], 1'b1, 1'b1, h.id[17:0], h.rtr};
        else
            w = {h.id[10:0], h.rtr, 1'b0, 19'd0};
        return w;
    endfunction

endpackage

// File: rtl/can_id_filter_regs.sv
module can_id_filter_regs
    import can_id_filter_pkg::*;
#(
    parameter int NUM_BYTES = 8,
    parameter int ADDR_W    = 5
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   init_mode,
    input  logic                   cfg_we,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic [7:0]             cfg_wdata,
    output logic [NUM_BYTES*8-1:0] code_o,
    output logic [NUM_BYTES*8-1:0] mask_o,
    af_mode_e                      mode_o
);

    localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(2 * NUM_BYTES);

    logic wr_ok;
    assign wr_ok = cfg_we && init_mode;

    af_mode_e mode_q;

    for (genvar k = 0; k < NUM_BYTES; k++) begin : g_byte
        localparam logic [ADDR_W-1:0] CODE_ADDR = ADDR_W'(k);
        localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(NUM_BYTES + k);
        logic [7:0] code_q, mask_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                code_q <= 8'h00;
                mask_q <= 8'h00;
            end else if (wr_ok) begin
                if (cfg_addr == CODE_ADDR) code_q <= cfg_wdata;
                if (cfg_addr == MASK_ADDR) mask_q <= cfg_wdata;
            end
        end

        // byte 0 sits at the top so it lines up with the first header bits
        assign code_o[(NUM_BYTES-1-k)*8 +: 8] = code_q;
        assign mask_o[(NUM_BYTES-1-k)*8 +: 8] = mask_q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            mode_q <= AF_CLOSED;
        else if (wr_ok && cfg_addr == MODE_ADDR)
            mode_q <= af_mode_e'(cfg_wdata[1:0]);
    end

    assign mode_o = mode_q;

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (rst)
        !init_mode |=> ($stable(code_o) && $stable(mask_o) && $stable(mode_o)));

endmodule

// File: rtl/can_id_filter_match.sv
module can_id_filter_match
    import can_id_filter_pkg::*;
#(
    parameter int NUM_BYTES = 8
) (
    input  logic [HDR_W-1:0]       hdr_i,
    input  logic [NUM_BYTES*8-1:0] code_i,
    input  logic [NUM_BYTES*8-1:0] mask_i,
    input  af_mode_e               mode_i,
    output logic [NUM_BYTES-1:0]   hits_o
);

    localparam int TOP = NUM_BYTES * 8 - 1;
    localparam int N32 = NUM_BYTES / 4;
    localparam int N16 = NUM_BYTES / 2;
    localparam int N8  = NUM_BYTES;

    logic [N32-1:0] w32;
    logic [N16-1:0] w16;
    logic [N8-1:0]  w8;

    for (genvar i = 0; i < N32; i++) begin : g_w32
        assign w32[i] = ((hdr_i ^ code_i[TOP-32*i -: 32]) & ~mask_i[TOP-32*i -: 32]) == 32'd0;
    end

    for (genvar i = 0; i < N16; i++) begin : g_w16
        assign w16[i] = ((hdr_i[31:16] ^ code_i[TOP-16*i -: 16]) & ~mask_i[TOP-16*i -: 16]) == 16'd0;
    end

    for (genvar i = 0; i < N8; i++) begin : g_w8
        assign w8[i] = ((hdr_i[31:24] ^ code_i[TOP-8*i -: 8]) & ~mask_i[TOP-8*i -: 8]) == 8'd0;
    end

    always_comb begin
        unique case (mode_i)
            AF_W32:  hits_o = NUM_BYTES'(w32);
            AF_W16:  hits_o = NUM_BYTES'(w16);
            AF_W8:   hits_o = w8;
            default: hits_o = '0;
        endcase
    end

endmodule

// File: rtl/can_id_filter_prio.sv
module can_id_filter_prio #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     hits_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits_i[i]) idx_o = IDX_W'(i);
        end
        any_o = |hits_i;
    end

    always_comb begin
        if (any_o) begin
            assert_idx_is_hit_R7: assert (hits_i[idx_o]);
            assert_no_lower_hit_R7: assert ((hits_i & ((N'(1) << idx_o) - N'(1))) == '0);
        end
    end

endmodule

// File: rtl/can_id_filter.sv
module can_id_filter
    import can_id_filter_pkg::*;
#(
    parameter int NUM_BYTES = 8,
    parameter int ADDR_W    = 5,
    parameter int IDX_W     = $clog2(NUM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              init_mode,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              rx_valid,
    input  logic [28:0]       rx_id,
    input  logic              rx_ide,
    input  logic              rx_rtr,
    output logic              accept,
    output logic [IDX_W-1:0]  hit_idx
);

    logic [NUM_BYTES*8-1:0] code_w, mask_w;
    af_mode_e               mode_w;
    rx_hdr_t                hdr;
    logic [HDR_W-1:0]       hdr_word;
    logic [NUM_BYTES-1:0]   hits;
    logic                   any_hit;
    logic [IDX_W-1:0]       first_idx;
    logic                   accept_q;
    logic [IDX_W-1:0]       idx_q;

    can_id_filter_regs #(.NUM_BYTES(NUM_BYTES), .ADDR_W(ADDR_W)) regs_i (
        .clk(clk), .rst(rst), .init_mode(init_mode), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .code_o(code_w), .mask_o(mask_w), .mode_o(mode_w)
    );

    assign hdr      = '{id: rx_id, ide: rx_ide, rtr: rx_rtr};
    assign hdr_word = build_hdr(hdr);

    can_id_filter_match #(.NUM_BYTES(NUM_BYTES)) match_i (
        .hdr_i(hdr_word), .code_i(code_w), .mask_i(mask_w),
        .mode_i(mode_w), .hits_o(hits)
    );

    can_id_filter_prio #(.N(NUM_BYTES), .IDX_W(IDX_W)) prio_i (
        .hits_i(hits), .any_o(any_hit), .idx_o(first_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            accept_q <= 1'b0;
            idx_q    <= '0;
        end else if (rx_valid) begin
            accept_q <= any_hit;
            idx_q    <= any_hit ? first_idx : '0;
        end
    end

    assign accept  = accept_q;
    assign hit_idx = idx_q;

    assert_closed_rejects_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_valid && mode_w == AF_CLOSED) |=> !accept);

    assert_result_held_R8: assert property (@(posedge clk) disable iff (rst)
        !rx_valid |=> ($stable(accept) && $stable(hit_idx)));

    assert_reject_idx_zero_R8: assert property (@(posedge clk) disable iff (rst)
        !accept |-> hit_idx == '0);

endmodule

// File: tb/can_id_filter_tb.sv
module can_id_filter_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_mode = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        rx_valid = 1'b0;
    logic [28:0] rx_id = '0;
    logic        rx_ide = 1'b0;
    logic        rx_rtr = 1'b0;
    logic        accept;
    logic [2:0]  hit_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    can_id_filter dut_i (
        .clk(clk), .rst(rst), .init_mode(init_mode), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .rx_valid(rx_valid),
        .rx_id(rx_id), .rx_ide(rx_ide), .rx_rtr(rx_rtr),
        .accept(accept), .hit_idx(hit_idx)
    );

    // Bank contents per mode; byte 0 is the most significant byte.
    localparam logic [63:0] CODE_CFG [4] = '{
        64'h123A5678_123A0000,    // mode 0
        64'h123A_5678_123A_0000,  // mode 1
        64'h12_3A_56_78_12_00_00_00, // mode 2
        64'h123A5678_123A0000     // mode 3 (closed)
    };
    localparam logic [63:0] MASK_CFG [4] = '{
        64'h00000000_0000FFFF,
        64'h0000_0000_0000_FFFF,
        64'h00_00_00_00_00_00_00_FF,
        64'h00000000_0000FFFF
    };

    // {mode, ide, header word, expected accept, expected index}
    localparam logic [38:0] VECS [NVEC] = '{
        {2'd0, 1'b1, 32'h123A5678, 1'b1, 3'd0}, // R4 R7 both wide filters match
        {2'd0, 1'b1, 32'h123A1234, 1'b1, 3'd1}, // R4 R2 masked low half
        {2'd0, 1'b1, 32'h123A5679, 1'b1, 3'd1}, // R3 rtr bit compared
        {2'd0, 1'b1, 32'h133A5678, 1'b0, 3'd0}, // R4 no match
        {2'd0, 1'b0, 32'h12200000, 1'b0, 3'd0}, // R3 standard ide=0 rejected
        {2'd1, 1'b1, 32'h123A5678, 1'b1, 3'd0}, // R5
        {2'd1, 1'b1, 32'h56780000, 1'b1, 3'd1}, // R5
        {2'd1, 1'b1, 32'h133A5678, 1'b1, 3'd3}, // R5 all-dont-care filter
        {2'd2, 1'b1, 32'h123A5678, 1'b1, 3'd0}, // R6 R7 filters 0 and 4 match
        {2'd2, 1'b1, 32'h56780000, 1'b1, 3'd2}, // R6
        {2'd2, 1'b0, 32'h00000000, 1'b1, 3'd5}, // R6 R3 standard frame, R7 over 6,7
        {2'd2, 1'b1, 32'h78180000, 1'b1, 3'd3}, // R6
        {2'd2, 1'b1, 32'hF0180000, 1'b1, 3'd7}, // R6
        {2'd3, 1'b1, 32'h123A5678, 1'b0, 3'd0}  // R9 closed
    };

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got acc/idx=%0d/%0d expected %0d/%0d",
                     req, got[3], got[2:0], exp[3], exp[2:0]);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R11 address map: 0..7 code, 8..15 mask, 16 mode
    task automatic load_cfg(input int m);
        init_mode = 1'b1;
        for (int k = 0; k < 8; k++) begin
            wr(5'(k),     CODE_CFG[m][63-8*k -: 8]);
            wr(5'(8 + k), MASK_CFG[m][63-8*k -: 8]);
        end
        wr(5'd16, 8'(m));
        init_mode = 1'b0;
    endtask

    // Place a header word on the receive inputs.
    task automatic put_word(input logic ide, input logic [31:0] w);
        rx_ide = ide;
        if (ide) begin
            rx_id  = {w[31:21], w[18:1]};
            rx_rtr = w[0];
        end else begin
            rx_id  = {18'd0, w[31:21]};
            rx_rtr = w[20];
        end
    endtask

    task automatic strobe(input logic ide, input logic [31:0] w);
        @(negedge clk);
        put_word(ide, w);
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        int cyc = 0;
        while (!done) begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                checks++; fails++;
                $display("FAIL watchdog: got timeout expected completion");
                finish_run();
            end
        end
    end

    initial begin
        int cur_mode = -1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset outputs
        check("R1 reset", {accept, hit_idx}, 4'b0000);
        // R1 R9 reset leaves filter closed
        strobe(1'b1, 32'h123A5678);
        check("R1 closed after reset", {accept, hit_idx}, 4'b0000);

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            int m;
            string tag;
            m = int'(VECS[v][38:37]);
            if (m != cur_mode) begin
                load_cfg(m);
                cur_mode = m;
            end
            strobe(VECS[v][36], VECS[v][35:4]);
            case (m)
                0: tag = "R4";
                1: tag = "R5";
                2: tag = "R6";
                default: tag = "R9";
            endcase
            check($sformatf("%s vec %0d", tag, v), {accept, hit_idx}, VECS[v][3:0]);
        end

        // R10 writes outside init mode are ignored
        load_cfg(0);
        wr(5'd16, 8'd3);
        wr(5'd0, 8'hFF);
        strobe(1'b1, 32'h123A5678);
        check("R10 ignored writes", {accept, hit_idx}, 4'b1000);

        // R8 result changes only at the sampling edge
        @(negedge clk);
        put_word(1'b1, 32'h133A5678);
        rx_valid = 1'b1;
        #1;
        check("R8 before edge", {accept, hit_idx}, 4'b1000);
        @(negedge clk);
        rx_valid = 1'b0;
        check("R8 after edge reject", {accept, hit_idx}, 4'b0000);
        put_word(1'b1, 32'h123A1234);
        repeat (3) @(negedge clk);
        check("R8 held without strobe", {accept, hit_idx}, 4'b0000);
        strobe(1'b1, 32'h123A1234);
        check("R8 new strobe", {accept, hit_idx}, 4'b1001);
        put_word(1'b1, 32'h133A5678);
        repeat (3) @(negedge clk);
        check("R8 held accept", {accept, hit_idx}, 4'b1001);

        // R2 R11 mask byte 0 at address 8 makes the first byte dont-care
        init_mode = 1'b1;
        wr(5'd8, 8'hFF);
        init_mode = 1'b0;
        strobe(1'b1, 32'h133A5678);
        check("R2 masked byte", {accept, hit_idx}, 4'b1000);

        done = 1'b1;
        finish_run();
    end

endmodule